// File: doc/BRIEF.md
# S/PDIF Receiver Synchronization Controller

This block brings a biphase-mark serial audio receiver from reset to a locked state. The incoming line is taken through a two-flop synchronizer into the fast local sampling clock, and a free-running interval timer measures the time between line transitions. The controller can first wait for line activity. It then estimates the unit interval (UI) from the shortest interval it sees, which is the coarse stage. Next, the fine stage checks that 24 and then 40 consecutive intervals all fall into the one, two or three UI bands. Only when both windows pass is the unit estimate committed to the thresholds that downstream logic uses.

A failed fine window sends the controller back to the coarse stage, up to a programmable retry limit. The controller reports two separate error flags: one for a line that goes silent so that the timer overflows, and one for running out of retries. Once the controller is locked, it opens channel-status/user-data capture, and later audio capture, only at a block-start preamble. That preamble is an interval triple of 3 UI, 1 UI, 1 UI. A small configuration register holds the two-bit run field together with the data-format and stereo fields. The format and stereo fields are frozen while the run field reads 11.

The states, with their `phase` codes, are:

- IDLE (0): left to WAIT_ACT or COARSE when the run field becomes active.
- WAIT_ACT (1): left to COARSE after four transitions.
- COARSE (2): left to FINE_A after sixteen measured intervals, or to ERROR on overflow.
- FINE_A (3): left to FINE_B after 24 good intervals, to COARSE or ERROR on a bad interval, or to ERROR on overflow.
- FINE_B (4): left to SYNCED after 40 good intervals, to COARSE or ERROR on a bad interval, or to ERROR on overflow.
- SYNCED (5): left to ERROR on overflow.
- ERROR (6): held until the run field is cleared.

From every state, an inactive run field leads back to IDLE.

Top module: `spdif_sync_ctrl`

## Requirements
- R1: After reset, `phase` is 0 (IDLE), and `synced`, `sync_err`, `trans_err`, `cu_capture`, `audio_capture`, `unit_len`, `fmt` and `stereo` are all 0.
- R2: A write with `wr_enable` of 01 or 11 while idle moves `phase` to 1 (WAIT_ACT) if `wait_act` is 1, or to 2 (COARSE) if `wait_act` is 0. The new phase is visible two clock edges after the write edge.
- R3: A write with `wr_enable` of 00 or 10 returns `phase` to 0 from any state within two edges. It also clears `synced`, both error flags, both capture flags and `unit_len`.
- R4: In WAIT_ACT the controller stays put through three line transitions and enters COARSE on the fourth.
- R5: In COARSE the first transition only starts timing. The next sixteen intervals are measured, and the shortest of them, in clock cycles, becomes the UI estimate.
- R6: Intervals are classed against the estimate U: below U/2 is bad, below 1.5U is 1 UI, below 2.5U is 2 UI, below 3.5U is 3 UI, and anything longer is bad. After 24 and then 40 consecutive non-bad intervals the phase becomes 5 (SYNCED), `synced` rises, and `unit_len` takes U. Before that point `unit_len` stays 0.
- R7: A bad interval in FINE_A or FINE_B counts as a failed attempt. If the number of failures has reached `retry_max`, the phase becomes 6 (ERROR) and `sync_err` is set. Otherwise the controller returns to COARSE.
- R8: If the interval timer reaches 2^CNT_W-1 clocks with no transition in COARSE, FINE_A, FINE_B or SYNCED, the phase becomes 6 and `trans_err` is set. `sync_err` and `trans_err` are never both 1.
- R9: In SYNCED, `cu_capture` rises on the last interval of the first 3-1-1 UI triple. Any other interval sequence leaves it at 0.
- R10: `audio_capture` rises only on a 3-1-1 triple that completes while the run field is 11. It drops as soon as the run field leaves 11.
- R11: `fmt` and `stereo` take the written values unless the run field already reads 11. A write that sets 11 may still change them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_in | input | 1 | Asynchronous biphase-mark serial line |
| wr_en | input | 1 | Configuration write strobe |
| wr_enable | input | 2 | Run field value written |
| wr_fmt | input | 2 | Data-format field value written |
| wr_stereo | input | 1 | Stereo-mode field value written |
| wait_act | input | 1 | Wait for line activity before the coarse stage |
| retry_max | input | RET_W | Failed fine attempts allowed before sync error |
| phase | output | 3 | Current controller state code |
| synced | output | 1 | Fine synchronization complete |
| sync_err | output | 1 | Retry limit reached |
| trans_err | output | 1 | Interval timer overflow |
| unit_len | output | CNT_W | Committed UI length in clocks |
| cu_capture | output | 1 | Channel-status/user-data capture open |
| audio_capture | output | 1 | Audio sample capture open |
| fmt | output | 2 | Data-format field |
| stereo | output | 1 | Stereo-mode field |

## Verification
The coarse stream alternates 2 UI and 1 UI intervals. An estimator that kept the first or the largest interval would then pick a wrong UI, and the fine stage would never lock. The bench probes `synced` one interval before and one interval after the 64th fine interval, so a window counter that is off by one shows up as an early or late lock. Retries are run with a limit of two: a controller that counts failures wrongly raises `sync_err` after the first failure or misses it after the second. The capture flags are probed after interval runs that contain no preamble, after a preamble seen while the run field is 01, and after a preamble seen while it is 11. The format field is written while frozen, with the same write that freezes it, and together with a return to idle.

// File: rtl/spdif_sync_pkg.sv
package spdif_sync_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_WAIT_ACT = 3'd1,
        ST_COARSE   = 3'd2,
        ST_FINE_A   = 3'd3,
        ST_FINE_B   = 3'd4,
        ST_SYNCED   = 3'd5,
        ST_ERROR    = 3'd6
    } sync_state_e;

    typedef enum logic [1:0] {
        SYM_BAD = 2'd0,
        SYM_1UI = 2'd1,
        SYM_2UI = 2'd2,
        SYM_3UI = 2'd3
    } sym_class_e;

endpackage

// File: rtl/line_edge_sync.sv
module line_edge_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic edge_pulse
);
    logic meta_q, sync_q, prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            meta_q <= din;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign edge_pulse = sync_q ^ prev_q;
endmodule

// File: rtl/interval_timer.sv
module interval_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             edge_in,
    output logic [CNT_W:0]   len,
    output logic             ovf
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr || edge_in) begin
            cnt_q <= '0;
        end else if (cnt_q != CNT_MAX) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign len = {1'b0, cnt_q} + 1'b1;
    assign ovf = (cnt_q == CNT_MAX) && !edge_in && !clr;
endmodule

// File: rtl/symbol_classifier.sv
module symbol_classifier
    import spdif_sync_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic [CNT_W-1:0] unit,
    input  logic [CNT_W:0]   len,
    output sym_class_e       cls
);
    localparam int TW = CNT_W + 3;

    logic [TW-1:0] u_ext, half, lim_lo, lim_12, lim_23, lim_hi, len_ext;

    always_comb begin
        u_ext   = TW'(unit);
        half    = u_ext >> 1;
        lim_lo  = half;
        lim_12  = u_ext + half;
        lim_23  = (u_ext << 1) + half;
        lim_hi  = (u_ext << 1) + u_ext + half;
        len_ext = TW'(len);
        if (unit == '0 || len_ext < lim_lo) begin
            cls = SYM_BAD;
        end else if (len_ext < lim_12) begin
            cls = SYM_1UI;
        end else if (len_ext < lim_23) begin
            cls = SYM_2UI;
        end else if (len_ext < lim_hi) begin
            cls = SYM_3UI;
        end else begin
            cls = SYM_BAD;
        end
    end
endmodule

// File: rtl/spdif_sync_ctrl.sv
module spdif_sync_ctrl
    import spdif_sync_pkg::*;
#(
    parameter int CNT_W      = 8,
    parameter int RET_W      = 4,
    parameter int ACT_EDGES  = 4,
    parameter int COARSE_N   = 16,
    parameter int FINE_A_N   = 24,
    parameter int FINE_B_N   = 40
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_in,
    input  logic             wr_en,
    input  logic [1:0]       wr_enable,
    input  logic [1:0]       wr_fmt,
    input  logic             wr_stereo,
    input  logic             wait_act,
    input  logic [RET_W-1:0] retry_max,
    output logic [2:0]       phase,
    output logic             synced,
    output logic             sync_err,
    output logic             trans_err,
    output logic [CNT_W-1:0] unit_len,
    output logic             cu_capture,
    output logic             audio_capture,
    output logic [1:0]       fmt,
    output logic             stereo
);
    localparam int MAX_AB = (FINE_A_N > FINE_B_N) ? FINE_A_N : FINE_B_N;
    localparam int MAX_CW = (COARSE_N > ACT_EDGES) ? COARSE_N : ACT_EDGES;
    localparam int MAX_N  = (MAX_AB > MAX_CW) ? MAX_AB : MAX_CW;
    localparam int IDX_W  = $clog2(MAX_N + 1) + 1;

    localparam logic [IDX_W-1:0] LAST_ACT    = IDX_W'(ACT_EDGES - 1);
    localparam logic [IDX_W-1:0] LAST_COARSE = IDX_W'(COARSE_N - 1);
    localparam logic [IDX_W-1:0] LAST_FINE_A = IDX_W'(FINE_A_N - 1);
    localparam logic [IDX_W-1:0] LAST_FINE_B = IDX_W'(FINE_B_N - 1);

    // configuration register
    logic [1:0] en_q;
    logic [1:0] fmt_q;
    logic       stereo_q;
    logic       run, audio_mode;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q     <= 2'b00;
            fmt_q    <= 2'b00;
            stereo_q <= 1'b0;
        end else if (wr_en) begin
            en_q <= wr_enable;
            if (en_q != 2'b11) begin
                fmt_q    <= wr_fmt;
                stereo_q <= wr_stereo;
            end
        end
    end

    assign run        = en_q[0];
    assign audio_mode = (en_q == 2'b11);

    // line front end
    sync_state_e      state_q, state_d;
    logic             edge_w, ovf_w, tmr_clr;
    logic [CNT_W:0]   len_w;
    logic [CNT_W-1:0] coarse_q, unit_q, unit_sel;
    sym_class_e       cls_w;

    line_edge_sync u_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .din        (line_in),
        .edge_pulse (edge_w)
    );

    assign tmr_clr = (state_q == ST_IDLE) || (state_q == ST_WAIT_ACT) ||
                     (state_q == ST_ERROR);

    interval_timer #(.CNT_W(CNT_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (tmr_clr),
        .edge_in (edge_w),
        .len     (len_w),
        .ovf     (ovf_w)
    );

    assign unit_sel = (state_q == ST_SYNCED) ? unit_q : coarse_q;

    symbol_classifier #(.CNT_W(CNT_W)) u_class (
        .unit (unit_sel),
        .len  (len_w),
        .cls  (cls_w)
    );

    // stage bookkeeping
    logic [IDX_W-1:0] evt_q;
    logic             armed_q;
    logic [CNT_W:0]   min_q, min_next;
    logic [RET_W-1:0] fail_q;
    logic             fail_last, fine_state, measuring;
    sym_class_e       hist1_q, hist2_q;
    logic             b_hit;

    assign min_next   = (len_w < min_q) ? len_w : min_q;
    assign fail_last  = ({1'b0, fail_q} + 1'b1) >= {1'b0, retry_max};
    assign fine_state = (state_q == ST_FINE_A) || (state_q == ST_FINE_B);
    assign measuring  = fine_state || (state_q == ST_COARSE) ||
                        (state_q == ST_SYNCED);
    assign b_hit      = edge_w && (hist2_q == SYM_3UI) &&
                        (hist1_q == SYM_1UI) && (cls_w == SYM_1UI);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (!run) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    state_d = wait_act ? ST_WAIT_ACT : ST_COARSE;
                end
                ST_WAIT_ACT: begin
                    if (edge_w && evt_q == LAST_ACT) state_d = ST_COARSE;
                end
                ST_COARSE: begin
                    if (ovf_w) begin
                        state_d = ST_ERROR;
                    end else if (edge_w && armed_q && evt_q == LAST_COARSE) begin
                        state_d = ST_FINE_A;
                    end
                end
                ST_FINE_A, ST_FINE_B: begin
                    if (ovf_w) begin
                        state_d = ST_ERROR;
                    end else if (edge_w) begin
                        if (cls_w == SYM_BAD) begin
                            state_d = fail_last ? ST_ERROR : ST_COARSE;
                        end else if (state_q == ST_FINE_A && evt_q == LAST_FINE_A) begin
                            state_d = ST_FINE_B;
                        end else if (state_q == ST_FINE_B && evt_q == LAST_FINE_B) begin
                            state_d = ST_SYNCED;
                        end
                    end
                end
                ST_SYNCED: begin
                    if (ovf_w) state_d = ST_ERROR;
                end
                ST_ERROR: begin
                    state_d = ST_ERROR;
                end
                default: begin
                    state_d = ST_IDLE;
                end
            endcase
        end
    end

    // outputs and stage datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            evt_q         <= '0;
            armed_q       <= 1'b0;
            min_q         <= '1;
            coarse_q      <= '0;
            unit_q        <= '0;
            fail_q        <= '0;
            synced        <= 1'b0;
            sync_err      <= 1'b0;
            trans_err     <= 1'b0;
            hist1_q       <= SYM_BAD;
            hist2_q       <= SYM_BAD;
            cu_capture    <= 1'b0;
            audio_capture <= 1'b0;
        end else begin
            // per-stage counters
            if (state_d != state_q) begin
                evt_q   <= '0;
                armed_q <= 1'b0;
                min_q   <= '1;
            end else if (edge_w) begin
                if (state_q == ST_COARSE) begin
                    if (!armed_q) begin
                        armed_q <= 1'b1;
                    end else begin
                        evt_q <= evt_q + 1'b1;
                        min_q <= min_next;
                    end
                end else if (state_q == ST_WAIT_ACT || fine_state) begin
                    evt_q <= evt_q + 1'b1;
                end
            end

            // coarse estimate
            if (state_q == ST_COARSE && state_d == ST_FINE_A) begin
                coarse_q <= min_next[CNT_W-1:0];
            end

            // retry accounting
            if (state_q == ST_IDLE) begin
                fail_q <= '0;
            end else if (fine_state && state_d == ST_COARSE) begin
                fail_q <= fail_q + 1'b1;
            end

            // error flags
            if (!run) begin
                sync_err  <= 1'b0;
                trans_err <= 1'b0;
            end else begin
                if (fine_state && edge_w && state_d == ST_ERROR) sync_err <= 1'b1;
                if (measuring && ovf_w) trans_err <= 1'b1;
            end

            // lock and committed unit
            if (!run) begin
                synced <= 1'b0;
                unit_q <= '0;
            end else if (state_q == ST_FINE_B && state_d == ST_SYNCED) begin
                synced <= 1'b1;
                unit_q <= coarse_q;
            end else if (state_d == ST_ERROR) begin
                synced <= 1'b0;
            end

            // preamble-gated capture
            if (state_d != ST_SYNCED) begin
                hist1_q       <= SYM_BAD;
                hist2_q       <= SYM_BAD;
                cu_capture    <= 1'b0;
                audio_capture <= 1'b0;
            end else if (state_q == ST_SYNCED) begin
                if (!audio_mode) audio_capture <= 1'b0;
                if (edge_w) begin
                    hist2_q <= hist1_q;
                    hist1_q <= cls_w;
                    if (b_hit) begin
                        cu_capture <= 1'b1;
                        if (audio_mode) audio_capture <= 1'b1;
                    end
                end
            end
        end
    end

    assign phase    = state_q;
    assign unit_len = unit_q;
    assign fmt      = fmt_q;
    assign stereo   = stereo_q;
endmodule

// File: rtl/spdif_sync_chk.sv
module spdif_sync_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic [1:0] wr_enable,
    input logic [2:0] phase,
    input logic       synced,
    input logic       sync_err,
    input logic       trans_err,
    input logic       cu_capture,
    input logic       audio_capture,
    input logic [1:0] fmt,
    input logic       stereo,
    input logic [1:0] en_q
);
    // R3
    idle_on_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_enable[0]) |-> ##2 (phase == 3'd0));

    // R11
    cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && en_q == 2'b11) |=> ($stable(fmt) && $stable(stereo)));

    // R8
    err_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sync_err, trans_err}));

    // R6
    lock_from_fine_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(synced) |-> ($past(phase) == 3'd4));

    // R10
    audio_needs_cu_chk: assert property (@(posedge clk) disable iff (!rst_n)
        audio_capture |-> cu_capture);

    // R10
    audio_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        audio_capture |-> ($past(en_q) == 2'b11));

    // R4
    wait_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 3'd1) |=> (phase <= 3'd2));

    // R7
    error_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 3'd6) |=> (phase == 3'd6 || phase == 3'd0));
endmodule

bind spdif_sync_ctrl spdif_sync_chk u_sync_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_en         (wr_en),
    .wr_enable     (wr_enable),
    .phase         (phase),
    .synced        (synced),
    .sync_err      (sync_err),
    .trans_err     (trans_err),
    .cu_capture    (cu_capture),
    .audio_capture (audio_capture),
    .fmt           (fmt),
    .stereo        (stereo),
    .en_q          (en_q)
);

// File: tb/tb_spdif_sync_ctrl.sv
module tb_spdif_sync_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       line_in = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_enable = 2'b00;
    logic [1:0] wr_fmt = 2'b00;
    logic       wr_stereo = 1'b0;
    logic       wait_act = 1'b0;
    logic [3:0] retry_max = 4'd3;
    logic [2:0] phase;
    logic       synced, sync_err, trans_err, cu_capture, audio_capture, stereo;
    logic [7:0] unit_len;
    logic [1:0] fmt;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    spdif_sync_ctrl dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .line_in       (line_in),
        .wr_en         (wr_en),
        .wr_enable     (wr_enable),
        .wr_fmt        (wr_fmt),
        .wr_stereo     (wr_stereo),
        .wait_act      (wait_act),
        .retry_max     (retry_max),
        .phase         (phase),
        .synced        (synced),
        .sync_err      (sync_err),
        .trans_err     (trans_err),
        .unit_len      (unit_len),
        .cu_capture    (cu_capture),
        .audio_capture (audio_capture),
        .fmt           (fmt),
        .stereo        (stereo)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    task automatic write_cfg(input logic [1:0] en, input logic [1:0] f, input logic st);
        @(negedge clk);
        wr_en = 1'b1; wr_enable = en; wr_fmt = f; wr_stereo = st;
        @(negedge clk);
        wr_en = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic gap(input int n);
        repeat (n) @(negedge clk);
        line_in = ~line_in;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    function automatic int fine_len(input int i);
        case (i % 4)
            0:       return 24;
            3:       return 16;
            default: return 8;
        endcase
    endfunction

    task automatic t_reset();
        check("R1 phase", phase, 0);
        check("R1 synced", synced, 0);
        check("R1 sync_err", sync_err, 0);
        check("R1 trans_err", trans_err, 0);
        check("R1 cu", cu_capture, 0);
        check("R1 audio", audio_capture, 0);
        check("R1 unit", unit_len, 0);
        check("R1 fmt", fmt, 0);
    endtask

    task automatic t_cfg_lock();
        wait_act = 1'b1;
        write_cfg(2'b01, 2'd2, 1'b1);
        check("R11 fmt write", fmt, 2);
        check("R11 stereo write", stereo, 1);
        write_cfg(2'b11, 2'd1, 1'b0);
        check("R11 fmt same write", fmt, 1);
        check("R11 stereo same write", stereo, 0);
        write_cfg(2'b11, 2'd3, 1'b1);
        check("R11 fmt frozen", fmt, 1);
        check("R11 stereo frozen", stereo, 0);
        write_cfg(2'b00, 2'd0, 1'b0);
        check("R3 phase idle", phase, 0);
        check("R11 fmt frozen on clear", fmt, 1);
        write_cfg(2'b00, 2'd0, 1'b0);
        check("R11 fmt after clear", fmt, 0);
    endtask

    task automatic t_wait_act();
        wait_act = 1'b1;
        write_cfg(2'b01, 2'd0, 1'b0);
        check("R2 wait state", phase, 1);
        gap(8); gap(8); gap(8);
        settle();
        check("R4 three edges", phase, 1);
        gap(4);
        settle();
        check("R4 fourth edge", phase, 2);
        write_cfg(2'b10, 2'd0, 1'b0);
        check("R3 code 10 idles", phase, 0);
    endtask

    task automatic t_overflow();
        wait_act = 1'b0;
        write_cfg(2'b01, 2'd0, 1'b0);
        check("R2 direct coarse", phase, 2);
        repeat (200) @(negedge clk);
        check("R8 no early overflow", trans_err, 0);
        repeat (100) @(negedge clk);
        check("R8 trans_err", trans_err, 1);
        check("R8 error phase", phase, 6);
        check("R8 sync_err clear", sync_err, 0);
        write_cfg(2'b00, 2'd0, 1'b0);
        check("R3 trans_err cleared", trans_err, 0);
        check("R3 phase", phase, 0);
    endtask

    task automatic t_retry();
        wait_act = 1'b0;
        retry_max = 4'd2;
        write_cfg(2'b01, 2'd0, 1'b0);
        gap(8);
        for (int i = 0; i < 16; i++) gap(8);
        gap(40);
        settle();
        check("R7 first fail retries", phase, 2);
        check("R7 no sync_err yet", sync_err, 0);
        gap(4);
        for (int i = 0; i < 16; i++) gap(8);
        gap(40);
        settle();
        check("R7 sync_err", sync_err, 1);
        check("R7 error phase", phase, 6);
        check("R7 trans_err clear", trans_err, 0);
        write_cfg(2'b00, 2'd0, 1'b0);
        check("R3 sync_err cleared", sync_err, 0);
        retry_max = 4'd3;
    endtask

    task automatic t_full_sync();
        wait_act = 1'b0;
        write_cfg(2'b01, 2'd0, 1'b0);
        gap(8);
        for (int i = 0; i < 16; i++) gap((i % 2 == 0) ? 16 : 8);
        settle();
        check("R5 coarse done", phase, 3);
        check("R6 unit before lock", unit_len, 0);
        gap(fine_len(0) - 4);
        for (int i = 1; i < 63; i++) gap(fine_len(i));
        settle();
        check("R6 not locked at 63", synced, 0);
        check("R6 second window", phase, 4);
        gap(fine_len(63) - 4);
        settle();
        check("R6 synced", synced, 1);
        check("R6 phase synced", phase, 5);
        check("R5 unit shortest", unit_len, 8);
        check("R9 no cu before preamble", cu_capture, 0);
        gap(12); gap(16); gap(16);
        settle();
        check("R9 no preamble", cu_capture, 0);
        gap(20); gap(8); gap(8);
        settle();
        check("R9 cu capture", cu_capture, 1);
        check("R10 audio off at 01", audio_capture, 0);
        write_cfg(2'b11, 2'd2, 1'b1);
        check("R10 audio waits preamble", audio_capture, 0);
        check("R2 stays synced", phase, 5);
        gap(8); gap(16); gap(16);
        settle();
        check("R10 no preamble yet", audio_capture, 0);
        gap(20); gap(8); gap(8);
        settle();
        check("R10 audio capture", audio_capture, 1);
        write_cfg(2'b01, 2'd0, 1'b0);
        check("R10 audio drops", audio_capture, 0);
        check("R9 cu holds", cu_capture, 1);
        write_cfg(2'b00, 2'd0, 1'b0);
        check("R3 synced cleared", synced, 0);
        check("R3 cu cleared", cu_capture, 0);
        check("R3 unit cleared", unit_len, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        report();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_cfg_lock();
        t_wait_act();
        t_overflow();
        t_retry();
        t_full_sync();
        report();
        $finish;
    end
endmodule